// File: doc/BRIEF.md
# SDRAM Command Timing Gate

This block stands between a request sequencer and a two-bank synchronous DRAM. The sequencer presents one command at a time: a row open, a column read or write (plain or with automatic close), a single-bank close, a close of all banks, a mode-register load, a refresh or a self-refresh entry. The block holds the command back until every minimum spacing the device needs has run out. It then grants the command for exactly one cycle and passes it to the device side. It also tracks which banks have an open row. It refuses commands that make no sense for the current bank state, and it raises a violation when a row stays open longer than the device allows.

All spacings are given in nanoseconds as parameters. At elaboration they are turned into clock counts for the chosen clock period, CAS latency and burst length. Elaboration stops with an error when the clock period is too short for the chosen CAS latency (below 15 ns at latency 2, below 10 ns at latency 3), when the latency is neither 2 nor 3, or when the bank count is not a power of two of at least two. Each spacing runs on its own down-counter. A command is granted in the cycle in which every counter that applies to it reads zero.

Top module: `sdram_cmd_gate`

## Requirements
- R1: Command codes on `cmd_code` are 0 idle, 1 open row, 2 read, 3 write, 4 read with close, 5 write with close, 6 close bank, 7 close all, 8 mode load, 9 refresh, 10 self-refresh. `grant` is high only while `cmd_valid` is high and the code is one of 1 to 10. When granted, `iss_cmd`/`iss_bank` carry the command and bank in the same cycle. Otherwise they read 0.
- R2: A spacing of t ns becomes the smallest whole number of clock periods not below t (rounded up).
- R3: A read or write of either kind to a bank is granted no earlier than the row-to-column delay (30 ns) after that bank's row open.
- R4: A close of a bank, a close-all, or a read/write with close is granted only once the minimum active time (50 ns) since the affected bank's open has passed.
- R5: Open-row, mode-load, refresh and self-refresh commands are spaced at least the row cycle time (80 ns) from any earlier one of the same group. After a mode load, the wait is the larger of that time and the mode-load delay (20 ns).
- R6: After a close or close-all, no open-row, mode-load, refresh or self-refresh command is granted for the precharge time (30 ns).
- R7: Row opens in two different banks are at least the bank-to-bank delay (20 ns) apart.
- R8: After a plain write, a close of that bank waits until the last data beat (burst length − 1 cycles after the write) plus the write recovery time (10 ns).
- R9: After a read with close, the next group-R5 command waits until the last data-out beat (CAS latency + burst − 1 cycles after the read) plus the precharge time less (CAS latency − 1) periods, with the wait never taken below zero. After a write with close, the wait runs from the last data-in beat and is the precharge time plus one period.
- R10: A read or write to a bank with no open row, or a row open to a bank whose row is already open, sets `viol` in that cycle and is not granted. A close-all closes every bank. A read or write with close closes its bank.
- R11: `viol` is high in every cycle in which some bank's row has been open for more than the maximum active time (100000 ns by default), counted from the cycle after its open. It stays high until that bank is closed.
- R12: After reset all banks are idle, all counters are zero, `viol` is low, and the first legal command is granted in the first cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_code | input | 4 | Command code (see R1) |
| cmd_bank | input | BANK_W | Target bank |
| grant | output | 1 | Command accepted this cycle |
| iss_cmd | output | 4 | Command passed to the device, 0 when none |
| iss_bank | output | BANK_W | Bank passed to the device, 0 when none |
| viol | output | 1 | Illegal command or row held open too long |

## Verification
The properties assume that the requester keeps a command steady while it waits. They also assume that it drops an illegal command after the cycle in which `viol` reports it, and that it never presents codes 11 to 15. The stimulus keeps to these rules. It presents each command until the reference model predicts a grant or a refusal, and only then moves on. The model uses its own arithmetic for rounded-up cycle counts and earliest-allowed cycle numbers. The clock period is set to 12 ns so that several spacings must round up. The maximum active time is shortened so that an overlong open row can be reached and then closed.

// File: rtl/sdram_gate_pkg.sv
`timescale 1ns/1ps
package sdram_gate_pkg;

   typedef enum logic [3:0] {
      C_IDLE  = 4'd0,
      C_OPEN  = 4'd1,
      C_RD    = 4'd2,
      C_WR    = 4'd3,
      C_RDC   = 4'd4,
      C_WRC   = 4'd5,
      C_CLOSE = 4'd6,
      C_CLALL = 4'd7,
      C_MODE  = 4'd8,
      C_REFR  = 4'd9,
      C_SELF  = 4'd10
   } gate_cmd_e;

   // nanoseconds to clock periods, rounded up, negative clamps to zero
   function automatic int ns_to_cyc(input int ns, input int period);
      return (ns <= 0) ? 0 : (ns + period - 1) / period;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // value loaded at the grant edge so the counter hits zero n cycles later
   function automatic int load_of(input int n);
      return (n > 0) ? n - 1 : 0;
   endfunction

endpackage

// File: rtl/sdram_gate_dcnt.sv
`timescale 1ns/1ps
module sdram_gate_dcnt #(
   parameter int W       = 4,
   parameter bit MAXLOAD = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);
   logic [W-1:0] cnt_q, dec, nxt;

   assign dec  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
   assign zero = (cnt_q == '0);

   generate
      if (MAXLOAD) begin : g_max
         // keep the later of the pending and the new deadline
         assign nxt = (load && (val > dec)) ? val : dec;
      end else begin : g_plain
         assign nxt = load ? val : dec;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt;
   end
endmodule

// File: rtl/sdram_gate_bank.sv
`timescale 1ns/1ps
module sdram_gate_bank #(
   parameter int CW        = 4,
   parameter int AW        = 8,
   parameter int RCD_L     = 2,
   parameter int RASMIN_L  = 4,
   parameter int WR_L      = 3,
   parameter int RASMAX_C  = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic do_open,
   input  logic do_wr,
   input  logic do_close,
   output logic is_open,
   output logic col_ok,
   output logic close_ok,
   output logic overrun
);
   logic          ras_z, wr_z;
   logic [AW-1:0] age_q;

   sdram_gate_dcnt #(.W(CW), .MAXLOAD(1'b0)) u_rcd (
      .clk(clk), .rst_n(rst_n), .load(do_open), .val(CW'(RCD_L)), .zero(col_ok));

   sdram_gate_dcnt #(.W(CW), .MAXLOAD(1'b0)) u_rasmin (
      .clk(clk), .rst_n(rst_n), .load(do_open), .val(CW'(RASMIN_L)), .zero(ras_z));

   sdram_gate_dcnt #(.W(CW), .MAXLOAD(1'b1)) u_wrec (
      .clk(clk), .rst_n(rst_n), .load(do_wr), .val(CW'(WR_L)), .zero(wr_z));

   assign close_ok = ras_z && wr_z;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         age_q   <= '0;
      end else begin
         if (do_open)       is_open <= 1'b1;
         else if (do_close) is_open <= 1'b0;
         if (do_open)
            age_q <= AW'(1);
         else if (is_open && (age_q <= AW'(RASMAX_C)))
            age_q <= age_q + 1'b1;
      end
   end

   assign overrun = is_open && (age_q > AW'(RASMAX_C));
endmodule

// File: rtl/sdram_cmd_gate.sv
`timescale 1ns/1ps
module sdram_cmd_gate
   import sdram_gate_pkg::*;
#(
   parameter int NUM_BANKS     = 2,
   parameter int TCK_NS        = 10,
   parameter int CAS_LAT       = 3,
   parameter int BURST_LEN     = 4,
   parameter int T_RCD_NS      = 30,
   parameter int T_RAS_MIN_NS  = 50,
   parameter int T_RAS_MAX_NS  = 100000,
   parameter int T_RC_NS       = 80,
   parameter int T_RP_NS       = 30,
   parameter int T_RRD_NS      = 20,
   parameter int T_RSA_NS      = 20,
   parameter int T_WR_NS       = 10,
   localparam int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_code,
   input  logic [BANK_W-1:0] cmd_bank,
   output logic              grant,
   output logic [3:0]        iss_cmd,
   output logic [BANK_W-1:0] iss_bank,
   output logic              viol
);
   // cycle counts
   localparam int RCD_C    = ns_to_cyc(T_RCD_NS, TCK_NS);
   localparam int RASMIN_C = ns_to_cyc(T_RAS_MIN_NS, TCK_NS);
   localparam int RASMAX_C = ns_to_cyc(T_RAS_MAX_NS, TCK_NS);
   localparam int RC_C     = ns_to_cyc(T_RC_NS, TCK_NS);
   localparam int RP_C     = ns_to_cyc(T_RP_NS, TCK_NS);
   localparam int RRD_C    = ns_to_cyc(T_RRD_NS, TCK_NS);
   localparam int RSA_C    = ns_to_cyc(T_RSA_NS, TCK_NS);
   localparam int WR_C     = ns_to_cyc(T_WR_NS, TCK_NS);
   localparam int APR_C    = ns_to_cyc(T_RP_NS - (CAS_LAT - 1) * TCK_NS, TCK_NS);
   // counter loads, measured from the command cycle
   localparam int RCD_L    = load_of(RCD_C);
   localparam int RASMIN_L = load_of(RASMIN_C);
   localparam int RC_L     = load_of(RC_C);
   localparam int MODE_L   = load_of(imax(RC_C, RSA_C));
   localparam int RP_L     = load_of(RP_C);
   localparam int RRD_L    = load_of(RRD_C);
   localparam int WR_L     = load_of(BURST_LEN - 1 + WR_C);
   localparam int APR_L    = load_of(CAS_LAT + BURST_LEN - 1 + APR_C);
   localparam int APW_L    = load_of(BURST_LEN - 1 + RP_C + 1);
   localparam int MAXL     = imax(imax(imax(RCD_L, RASMIN_L), imax(MODE_L, RP_L)),
                                  imax(imax(RRD_L, WR_L), imax(APR_L, APW_L)));
   localparam int CW       = imax(1, $clog2(MAXL + 1));
   localparam int AW       = imax(1, $clog2(RASMAX_C + 2));

   // elaboration checks
   if (CAS_LAT != 2 && CAS_LAT != 3) begin : g_bad_cl
      $error("CAS latency must be 2 or 3");
   end
   if (CAS_LAT == 2 && TCK_NS < 15) begin : g_bad_tck2
      $error("clock period below 15 ns at CAS latency 2");
   end
   if (CAS_LAT == 3 && TCK_NS < 10) begin : g_bad_tck3
      $error("clock period below 10 ns at CAS latency 3");
   end
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_nb
      $error("bank count must be a power of two, at least two");
   end
   if (BURST_LEN < 1) begin : g_bad_bl
      $error("burst length must be positive");
   end

   logic is_open_c, is_rd, is_wr, is_rdc, is_wrc, is_close, is_clall;
   logic is_mode, is_refr, is_self, is_col, is_auto, is_row;
   logic [NUM_BANKS-1:0] bank_open, col_ok, close_ok, overrun;
   logic [NUM_BANKS-1:0] do_open, do_wr, do_close;
   logic rc_z, pc_z, rrd_z, tgt_open, illegal, timing_ok;

   assign is_open_c = (cmd_code == C_OPEN);
   assign is_rd     = (cmd_code == C_RD);
   assign is_wr     = (cmd_code == C_WR);
   assign is_rdc    = (cmd_code == C_RDC);
   assign is_wrc    = (cmd_code == C_WRC);
   assign is_close  = (cmd_code == C_CLOSE);
   assign is_clall  = (cmd_code == C_CLALL);
   assign is_mode   = (cmd_code == C_MODE);
   assign is_refr   = (cmd_code == C_REFR);
   assign is_self   = (cmd_code == C_SELF);
   assign is_auto   = is_rdc || is_wrc;
   assign is_col    = is_rd || is_wr || is_auto;
   assign is_row    = is_open_c || is_mode || is_refr || is_self;

   assign tgt_open  = bank_open[cmd_bank];
   assign illegal   = cmd_valid && ((is_open_c && tgt_open) || (is_col && !tgt_open));

   always_comb begin
      timing_ok = 1'b0;
      if (is_open_c)            timing_ok = rc_z && pc_z && rrd_z;
      else if (is_rd || is_wr)  timing_ok = col_ok[cmd_bank];
      else if (is_auto)         timing_ok = col_ok[cmd_bank] && close_ok[cmd_bank];
      else if (is_close)        timing_ok = close_ok[cmd_bank];
      else if (is_clall)        timing_ok = &close_ok;
      else if (is_row)          timing_ok = rc_z && pc_z;
   end

   assign grant    = cmd_valid && !illegal && timing_ok;
   assign iss_cmd  = grant ? cmd_code : 4'd0;
   assign iss_bank = grant ? cmd_bank : '0;
   assign viol     = illegal || (|overrun);

   // shared spacings
   sdram_gate_dcnt #(.W(CW), .MAXLOAD(1'b1)) u_rowcyc (
      .clk(clk), .rst_n(rst_n), .load(grant && is_row),
      .val(is_mode ? CW'(MODE_L) : CW'(RC_L)), .zero(rc_z));

   sdram_gate_dcnt #(.W(CW), .MAXLOAD(1'b1)) u_prech (
      .clk(clk), .rst_n(rst_n), .load(grant && (is_close || is_clall || is_auto)),
      .val(is_rdc ? CW'(APR_L) : (is_wrc ? CW'(APW_L) : CW'(RP_L))), .zero(pc_z));

   sdram_gate_dcnt #(.W(CW), .MAXLOAD(1'b0)) u_rrd (
      .clk(clk), .rst_n(rst_n), .load(grant && is_open_c),
      .val(CW'(RRD_L)), .zero(rrd_z));

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic sel;
      assign sel         = (cmd_bank == BANK_W'(i));
      assign do_open[i]  = grant && is_open_c && sel;
      assign do_wr[i]    = grant && is_wr && sel;
      assign do_close[i] = grant && (is_clall || ((is_close || is_auto) && sel));

      sdram_gate_bank #(
         .CW(CW), .AW(AW), .RCD_L(RCD_L), .RASMIN_L(RASMIN_L),
         .WR_L(WR_L), .RASMAX_C(RASMAX_C)
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .do_open(do_open[i]), .do_wr(do_wr[i]), .do_close(do_close[i]),
         .is_open(bank_open[i]), .col_ok(col_ok[i]),
         .close_ok(close_ok[i]), .overrun(overrun[i]));
   end
endmodule

// File: rtl/sdram_gate_chk.sv
`timescale 1ns/1ps
module sdram_gate_chk #(
   parameter int NB   = 2,
   parameter int BW   = 1,
   parameter int RC_C = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic [3:0]    cmd_code,
   input logic [BW-1:0] cmd_bank,
   input logic          grant,
   input logic [3:0]    iss_cmd,
   input logic          viol,
   input logic [NB-1:0] bank_open
);
   logic row_c, col_c;
   int   gap_q;
   logic seen_q;

   assign row_c = (cmd_code == 4'd1) || (cmd_code == 4'd8) ||
                  (cmd_code == 4'd9) || (cmd_code == 4'd10);
   assign col_c = (cmd_code >= 4'd2) && (cmd_code <= 4'd5);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= 0;
         seen_q <= 1'b0;
      end else if (grant && row_c) begin
         gap_q  <= 1;
         seen_q <= 1'b1;
      end else if (gap_q < RC_C) begin
         gap_q  <= gap_q + 1;
      end
   end

   p_grant_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> cmd_valid);

   p_idle_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |-> (iss_cmd == 4'd0));

   p_rc_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && row_c && seen_q) |-> (gap_q >= RC_C));

   p_col_needs_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && col_c) |-> bank_open[cmd_bank]);

   p_open_needs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && cmd_code == 4'd1) |-> !bank_open[cmd_bank]);

   p_idle_col_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && col_c && !bank_open[cmd_bank]) |-> (viol && !grant));

   p_clall_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && cmd_code == 4'd7) |=> (bank_open == '0));

   p_open_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && cmd_code == 4'd1) |=> bank_open[$past(cmd_bank)]);
endmodule

bind sdram_cmd_gate sdram_gate_chk #(.NB(NUM_BANKS), .BW(BANK_W), .RC_C(RC_C)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
   .cmd_bank(cmd_bank), .grant(grant), .iss_cmd(iss_cmd), .viol(viol),
   .bank_open(bank_open));

// File: tb/sdram_cmd_gate_test.sv
`timescale 1ns/1ps
module sdram_cmd_gate_test;
   localparam int TCK = 12, CL = 3, BL = 4, RASMAX_NS = 500;

   function automatic int cyc(input int ns);
      if (ns <= 0) return 0;
      return ns / TCK + ((ns % TCK) != 0 ? 1 : 0);
   endfunction
   function automatic int mx(input int a, input int b);
      return a > b ? a : b;
   endfunction

   localparam int E_RCD = cyc(30), E_RASMIN = cyc(50), E_RASMAX = cyc(RASMAX_NS);
   localparam int E_RC = cyc(80), E_RP = cyc(30), E_RRD = cyc(20), E_RSA = cyc(20);
   localparam int E_WR = cyc(10), E_APR = cyc(30 - (CL - 1) * TCK);

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, cmd_valid, cmd_bank, grant, iss_bank, viol;
   logic [3:0] cmd_code, iss_cmd;

   sdram_cmd_gate #(
      .TCK_NS(TCK), .CAS_LAT(CL), .BURST_LEN(BL), .T_RAS_MAX_NS(RASMAX_NS)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_bank(cmd_bank), .grant(grant), .iss_cmd(iss_cmd),
      .iss_bank(iss_bank), .viol(viol));

   int vectors = 0, errors = 0, now = 0;
   bit finished = 1'b0;
   // reference model: earliest permitted cycle numbers
   int ok_col[2], ok_pre[2], act_t[2];
   bit opn[2];
   int ok_row = 0, ok_act = 0;
   logic dv = 1'b0;
   logic [3:0] dc = 4'd0;
   logic db = 1'b0;

   task automatic model_eval(output bit eg, output bit ill, output bit ev);
      bit ready, col;
      int b;
      b = int'(db);
      col = (dc >= 4'd2) && (dc <= 4'd5);
      ill = dv && ((dc == 4'd1 && opn[b]) || (col && !opn[b]));
      case (dc)
         4'd1:       ready = now >= ok_row && now >= ok_act;
         4'd2, 4'd3: ready = now >= ok_col[b];
         4'd4, 4'd5: ready = now >= ok_col[b] && now >= ok_pre[b];
         4'd6:       ready = now >= ok_pre[b];
         4'd7:       ready = now >= ok_pre[0] && now >= ok_pre[1];
         4'd8, 4'd9, 4'd10: ready = now >= ok_row;
         default:    ready = 1'b0;
      endcase
      eg = dv && !ill && ready;
      ev = ill || (opn[0] && now - act_t[0] > E_RASMAX) || (opn[1] && now - act_t[1] > E_RASMAX);
   endtask

   task automatic model_update();
      int b;
      b = int'(db);
      case (dc)
         4'd1: begin
            opn[b] = 1'b1; act_t[b] = now;
            ok_col[b] = now + E_RCD; ok_pre[b] = now + E_RASMIN;
            ok_row = mx(ok_row, now + E_RC); ok_act = now + E_RRD;
         end
         4'd3: ok_pre[b] = mx(ok_pre[b], now + BL - 1 + E_WR);
         4'd4: begin opn[b] = 1'b0; ok_row = mx(ok_row, now + CL + BL - 1 + E_APR); end
         4'd5: begin opn[b] = 1'b0; ok_row = mx(ok_row, now + BL - 1 + E_RP + 1); end
         4'd6: begin opn[b] = 1'b0; ok_row = mx(ok_row, now + E_RP); end
         4'd7: begin opn[0] = 1'b0; opn[1] = 1'b0; ok_row = mx(ok_row, now + E_RP); end
         4'd8: ok_row = mx(ok_row, now + mx(E_RC, E_RSA));
         4'd9, 4'd10: ok_row = mx(ok_row, now + E_RC);
         default: ;
      endcase
   endtask

   task automatic cycle(input string tag, output bit done);
      bit eg, ill, ev;
      logic [3:0] ec;
      logic eb;
      @(negedge clk);
      cmd_valid = dv; cmd_code = dc; cmd_bank = db;
      #1;
      model_eval(eg, ill, ev);
      ec = eg ? dc : 4'd0;
      eb = eg ? db : 1'b0;
      vectors++;
      if (grant !== eg || iss_cmd !== ec || iss_bank !== eb || viol !== ev) begin
         errors++;
         $display("FAIL %s t=%0d: grant=%0b cmd=%0d bank=%0b viol=%0b, expected grant=%0b cmd=%0d bank=%0b viol=%0b",
                  tag, now, grant, iss_cmd, iss_bank, viol, eg, ec, eb, ev);
      end
      @(posedge clk);
      if (eg) model_update();
      now++;
      done = eg || ill;
   endtask

   task automatic issue(input logic [3:0] c, input logic b, input string tag);
      bit done = 1'b0;
      dv = 1'b1; dc = c; db = b;
      for (int k = 0; k < 80 && !done; k++) cycle(tag, done);
      if (!done) begin
         errors++;
         $display("FAIL %s: command %0d never resolved, expected grant or refusal", tag, c);
      end
      dv = 1'b0; dc = 4'd0; db = 1'b0;
   endtask

   task automatic idle(input int n, input string tag);
      bit d;
      dv = 1'b0; dc = 4'd0; db = 1'b0;
      for (int k = 0; k < n; k++) cycle(tag, d);
   endtask

   task automatic poke(input logic [3:0] c, input logic b, input string tag);
      bit d;
      dv = 1'b1; dc = c; db = b;
      cycle(tag, d);
      dv = 1'b0; dc = 4'd0; db = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 2; i++) begin ok_col[i] = 0; ok_pre[i] = 0; act_t[i] = 0; opn[i] = 1'b0; end
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 4'd0; cmd_bank = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      idle(2, "R12");                  // reset state
      issue(4'd9, 1'b0, "R12");        // granted at once after reset
      poke(4'd0, 1'b0, "R1");          // idle code with valid: no grant
      issue(4'd1, 1'b0, "R5");         // open waits row cycle after refresh
      issue(4'd1, 1'b1, "R7");         // bank-to-bank open spacing
      issue(4'd2, 1'b0, "R2,R3");      // rounded row-to-column delay
      issue(4'd3, 1'b1, "R3");
      issue(4'd6, 1'b1, "R8");         // write recovery before close
      issue(4'd6, 1'b0, "R4");         // minimum active time
      issue(4'd1, 1'b0, "R6");         // precharge time before open
      issue(4'd4, 1'b0, "R4,R9");      // read with close
      issue(4'd1, 1'b0, "R9");         // open after read-close wait
      issue(4'd5, 1'b0, "R9");         // write with close
      issue(4'd9, 1'b0, "R9");         // refresh after write-close wait
      issue(4'd8, 1'b0, "R5");         // mode load after refresh
      issue(4'd1, 1'b1, "R5");         // open after mode load
      issue(4'd2, 1'b0, "R10");        // read to idle bank refused
      issue(4'd1, 1'b1, "R10");        // open of open bank refused
      issue(4'd1, 1'b0, "R7");
      issue(4'd3, 1'b0, "R1");
      issue(4'd7, 1'b0, "R10");        // close all, after write recovery
      issue(4'd3, 1'b1, "R10");        // write after close-all refused
      issue(4'd10, 1'b0, "R5");
      issue(4'd1, 1'b1, "R11");
      idle(E_RASMAX + 4, "R11");       // row held past maximum active time
      issue(4'd6, 1'b1, "R11");        // close clears the flag
      idle(3, "R11");
      summary();
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
      end
   end
endmodule